// File: doc/BRIEF.md
# Dual-Mono I2S Serial Audio Port

This block is the master side of a two-timeslot serial audio link. It makes a bit clock from the system clock with a programmable divider. It also drives a word-alignment signal at the sample rate. Each sample period holds 32 bit clocks: one 16-bit timeslot while word alignment is high, then one while it is low. One mono transmit sample, a 16-bit two's-complement word, is sent MSB first in both timeslots. On the receive side, only the word that arrives in the high timeslot is kept and returned as the mono sample. The bits of the low timeslot are dropped.

Two configuration inputs shape the bit timing. One selects which bit-clock edge launches transmit data; receive data is always sampled on the other edge. The other chooses whether the MSB starts on the word-alignment transition itself or one bit clock later. In the delayed form, the last bit of each timeslot carries over into the first bit period of the next one. The receive window moves by the same bit. All launch and capture work happens on single-cycle strobes in the system clock domain. The generated bit clock is only an output pin. Transmit words come in through a ready/valid handshake, once per sample period. Received words leave with a one-cycle valid pulse.

Top module: `i2s_dualmono_port`

## Requirements
- R1: The bit clock `sck` toggles every `cfg_half_div`+1 system clocks, starting low after reset. While the configuration is unchanged, successive rising edges of `ws` are 64×(`cfg_half_div`+1) system clocks apart, which is 32 bit clocks.
- R2: `ws` stays high for 16 bit clocks, which is 32×(`cfg_half_div`+1) system clocks, and then low for 16. The high timeslot opens each sample period.
- R3: With `cfg_msb_delay`=0, the 32 bits on `sd_out` in a sample period, taken in order from the rise of `ws`, are the accepted word MSB first (bit 15 first) and then the same word again.
- R4: With `cfg_msb_delay`=1, the 32 bits of a period, in order, are: bit 0 of the previous period's word, then bits 15..1 of the current word, then bit 0 of the current word, then bits 15..1 again.
- R5: With `cfg_launch_fall`=0, `sd_out` and `ws` change only with a rising `sck` edge. With `cfg_launch_fall`=1, they change only with a falling edge. `sd_in` is sampled on the opposite edge.
- R6: `rx_data` is the 16 bits sampled in the high timeslot, MSB first. These are the bit positions 0..15 after the rise of `ws`, or 1..16 when the MSB is delayed. Bits in all other positions have no effect on it.
- R7: `rx_valid` pulses for exactly one system cycle per sample period. The pulse comes in the cycle after the final receive bit is sampled, with the new word on `rx_data`.
- R8: `tx_ready` is high for one system cycle per sample period, in the cycle before `ws` rises. A word offered with `tx_valid` in that cycle is sent in the new period. If no word is offered, the previous word is sent again; the word after reset is 0.
- R9: A change on `cfg_launch_fall` or `cfg_msb_delay` takes effect only from the next sample period. It is taken at the last receive strobe before that period starts. The periods before the change keep their old bit layout.
- R10: While `rst` is high, `sck`, `ws`, `sd_out`, `tx_ready` and `rx_valid` are all 0. The first sample period then uses rising-edge launch with no MSB delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| cfg_launch_fall | input | 1 | 1: transmit launched on falling `sck`, 0: on rising |
| cfg_msb_delay | input | 1 | 1: MSB one bit clock after the `ws` edge |
| tx_data | input | 16 | Mono transmit sample, two's complement |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Sample-period boundary; word accepted if valid |
| rx_data | output | 16 | Mono sample from the high timeslot |
| rx_valid | output | 1 | One-cycle pulse: new `rx_data` |
| sck | output | 1 | Generated bit clock |
| ws | output | 1 | Word alignment, high for the first timeslot |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |

## Verification
The bench builds the block with DIV_W=4 and runs the same vector table three times, at half-divider values 1, 0 and 3. The smallest value toggles the bit clock on every system cycle, which puts launch and capture strobes one cycle apart. The larger values test that frame timing scales with the divider. The table covers both launch edges, both MSB placements, switches of each setting between sample periods, and underruns in both modes. On the receive side, the bench drives inverted data in every position outside the high-timeslot window.

// File: rtl/i2s_dm_pkg.sv
package i2s_dm_pkg;

    localparam int SLOT_W  = 16;
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W);

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [SLOT_W-1:0] word_t;

    typedef struct packed {
        logic launch_fall;
        logic msb_delay;
    } port_cfg_t;

    typedef struct packed {
        logic launch;
        logic capture;
        logic boundary;
    } bit_strobe_t;

    // Data position within the period: one behind the slot position when the MSB is delayed.
    function automatic pos_t data_pos(pos_t p, logic dly);
        return dly ? pos_t'(p - pos_t'(1)) : p;
    endfunction

    function automatic logic in_first_slot(pos_t dp);
        return ~dp[POS_W-1];
    endfunction

endpackage

// File: rtl/i2s_dm_clkgen.sv
module i2s_dm_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] div_cnt;
    logic             wrap;

    assign wrap     = (div_cnt >= half_div) && !rst;
    assign rise_stb = wrap && !sck;
    assign fall_stb = wrap && sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            sck     <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            sck     <= ~sck;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R1
    sck_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sck)) |-> ($past(div_cnt) >= $past(half_div)));

endmodule

// File: rtl/i2s_dm_framer.sv
module i2s_dm_framer
    import i2s_dm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  port_cfg_t   cfg_in,
    output port_cfg_t   cfg_act,
    output pos_t        pos,
    output logic        ws,
    output bit_strobe_t stb
);
    pos_t pos_nxt;
    logic cfg_load;

    assign stb.launch   = cfg_act.launch_fall ? fall_stb : rise_stb;
    assign stb.capture  = cfg_act.launch_fall ? rise_stb : fall_stb;
    assign stb.boundary = stb.launch && (pos == pos_t'(FRAME_W - 1));
    assign cfg_load     = stb.capture && (pos == pos_t'(FRAME_W - 1));
    assign pos_nxt      = pos + pos_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= pos_t'(FRAME_W - 1);
            ws      <= 1'b0;
            cfg_act <= '0;
        end else begin
            if (stb.launch) begin
                pos <= pos_nxt;
                ws  <= ~pos_nxt[POS_W-1];
            end
            if (cfg_load) begin
                cfg_act <= cfg_in;
            end
        end
    end

    // R2
    ws_rise_pos_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ws) |-> (pos == '0));

    // R2
    ws_fall_pos_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ws) |-> (pos == pos_t'(SLOT_W)));

    // R9
    cfg_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_act)) |-> ($past(pos) == pos_t'(FRAME_W - 1)));

endmodule

// File: rtl/i2s_dm_tx.sv
module i2s_dm_tx
    import i2s_dm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  launch_stb,
    input  logic  boundary,
    input  pos_t  pos,
    input  logic  msb_delay,
    input  word_t tx_data,
    input  logic  tx_valid,
    output logic  tx_ready,
    output logic  sd_out
);
    word_t                 cur_word;
    word_t                 word_now;
    pos_t                  slot_pos;
    pos_t                  dpos;
    logic [POS_W-2:0]      sub_pos;
    logic                  bit_nxt;

    assign tx_ready = boundary;
    assign slot_pos = pos + pos_t'(1);
    assign dpos     = data_pos(slot_pos, msb_delay);
    assign sub_pos  = dpos[POS_W-2:0];
    assign word_now = (boundary && tx_valid) ? tx_data : cur_word;

    always_comb begin
        if (msb_delay && (slot_pos == '0)) begin
            bit_nxt = cur_word[0];
        end else begin
            bit_nxt = word_now[~sub_pos];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word <= '0;
            sd_out   <= 1'b0;
        end else if (launch_stb) begin
            sd_out <= bit_nxt;
            if (boundary && tx_valid) begin
                cur_word <= tx_data;
            end
        end
    end

    // R8
    underrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> $stable(cur_word));

    // R8
    accept_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && tx_valid) |=> (cur_word == $past(tx_data)));

endmodule

// File: rtl/i2s_dm_rx.sv
module i2s_dm_rx
    import i2s_dm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture_stb,
    input  pos_t  pos,
    input  logic  msb_delay,
    input  logic  sd_in,
    output word_t rx_data,
    output logic  rx_valid
);
    logic [SLOT_W-2:0] shreg;
    pos_t              dpos;
    logic              in_win;
    logic              last_bit;

    assign dpos     = data_pos(pos, msb_delay);
    assign in_win   = in_first_slot(dpos);
    assign last_bit = (dpos == pos_t'(SLOT_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (capture_stb && in_win) begin
                shreg <= {shreg[SLOT_W-3:0], sd_in};
                if (last_bit) begin
                    rx_data  <= {shreg, sd_in};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid) |-> $stable(rx_data));

endmodule

// File: rtl/i2s_dualmono_port.sv
module i2s_dualmono_port
    import i2s_dm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              cfg_launch_fall,
    input  logic              cfg_msb_delay,
    input  logic [SLOT_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [SLOT_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck,
    output logic              ws,
    output logic              sd_out,
    input  logic              sd_in
);
    logic        rise_stb;
    logic        fall_stb;
    port_cfg_t   cfg_req;
    port_cfg_t   cfg_act;
    pos_t        pos;
    bit_strobe_t stb;

    assign cfg_req.launch_fall = cfg_launch_fall;
    assign cfg_req.msb_delay   = cfg_msb_delay;

    i2s_dm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .half_div (cfg_half_div),
        .sck      (sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    i2s_dm_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .cfg_in   (cfg_req),
        .cfg_act  (cfg_act),
        .pos      (pos),
        .ws       (ws),
        .stb      (stb)
    );

    i2s_dm_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .launch_stb (stb.launch),
        .boundary   (stb.boundary),
        .pos        (pos),
        .msb_delay  (cfg_act.msb_delay),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .sd_out     (sd_out)
    );

    i2s_dm_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .capture_stb (stb.capture),
        .pos         (pos),
        .msb_delay   (cfg_act.msb_delay),
        .sd_in       (sd_in),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid)
    );

    // R8
    ready_ws_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |=> $rose(ws));

    // R5
    sd_launch_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sd_out)) |-> ((sck != $past(sck)) && (sck == !cfg_act.launch_fall)));

    // R5
    ws_launch_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ws)) |-> ((sck != $past(sck)) && (sck == !cfg_act.launch_fall)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sck && !ws && !sd_out && !rx_valid));

endmodule

// File: tb/i2s_dualmono_port_tb.sv
module i2s_dualmono_port_tb;

    localparam int DIV_W = 4;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic        lf;
        logic        dl;
        logic        vld;
        logic [15:0] tx;
        logic [15:0] rx;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 16'hA5C3, 16'h1234},
        '{1'b0, 1'b0, 1'b1, 16'h8001, 16'hFFFF},
        '{1'b0, 1'b1, 1'b1, 16'h7FFE, 16'h8000},
        '{1'b0, 1'b1, 1'b0, 16'h0F0F, 16'h0001},
        '{1'b1, 1'b1, 1'b1, 16'hC001, 16'hBEEF},
        '{1'b1, 1'b0, 1'b1, 16'h3C5A, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 16'h1111, 16'h5A5A},
        '{1'b0, 1'b0, 1'b1, 16'h0001, 16'h7FFF}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] cfg_half_div = '0;
    logic             cfg_launch_fall = 1'b0;
    logic             cfg_msb_delay = 1'b0;
    logic [15:0]      tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic [15:0]      rx_data;
    logic             rx_valid;
    logic             sck;
    logic             ws;
    logic             sd_out;
    logic             sd_in = 1'b0;

    logic [15:0] rxw = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    i2s_dualmono_port #(.DIV_W(DIV_W)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_half_div    (cfg_half_div),
        .cfg_launch_fall (cfg_launch_fall),
        .cfg_msb_delay   (cfg_msb_delay),
        .tx_data         (tx_data),
        .tx_valid        (tx_valid),
        .tx_ready        (tx_ready),
        .rx_data         (rx_data),
        .rx_valid        (rx_valid),
        .sck             (sck),
        .ws              (ws),
        .sd_out          (sd_out),
        .sd_in           (sd_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    function automatic logic rx_bit(input int p, input logic dl, input logic [15:0] w);
        int ep;
        ep = dl ? p - 1 : p;
        if (ep >= 0 && ep < 16) return w[15 - ep];
        if (ep < 0) return ~w[0];
        return ~w[15 - (ep % 16)];
    endfunction

    // Bench-side link model: frame capture, receive drive, timing checks
    logic        sck_q, ws_q, sd_q;
    logic        m_lf, m_dl, m_lf_prev;
    logic        have_prev, active, post_rst;
    logic [15:0] cur_w, prev_w, next_w, rx_w;
    logic [31:0] frame, exp_frame;
    int          pos, cap_n, rx_pulses, clocks, frames_done, edge_viol;

    always @(negedge clk) begin
        if (rst) begin
            sck_q = 1'b0; ws_q = 1'b0; sd_q = 1'b0;
            m_lf = 1'b0; m_dl = 1'b0; m_lf_prev = 1'b0;
            have_prev = 1'b0; active = 1'b0; post_rst = 1'b1;
            cur_w = '0; prev_w = '0; next_w = '0; rx_w = '0;
            pos = 0; cap_n = 0; rx_pulses = 0; clocks = 0;
            frames_done = 0; edge_viol = 0;
        end else begin
            clocks++;
            if (tx_ready) next_w = tx_valid ? tx_data : cur_w;
            if (ws && !ws_q) begin
                // R1: frame period while launch edge unchanged
                if (have_prev && (m_lf_prev == cfg_launch_fall))
                    check(clocks == 64 * (int'(cfg_half_div) + 1), "R1", "ws period",
                          clocks, 64 * (int'(cfg_half_div) + 1));
                clocks = 0;
                m_lf_prev = cfg_launch_fall;
                have_prev = 1'b1;
                m_lf = cfg_launch_fall;
                m_dl = cfg_msb_delay;
                prev_w = cur_w;
                cur_w = next_w;
                rx_w = rxw;
                pos = 0; cap_n = 0; rx_pulses = 0; active = 1'b1;
                frame = '0;
                sd_in = rx_bit(0, m_dl, rx_w);
            end else if (sck != sck_q && sck == !m_lf) begin
                pos++;
                sd_in = rx_bit(pos, m_dl, rx_w);
            end else if (sck != sck_q && active && cap_n < 32) begin
                frame[31 - cap_n] = sd_out;
                cap_n++;
                if (cap_n == 32) begin
                    if (m_dl) exp_frame = {prev_w[0], cur_w[15:1], cur_w[0], cur_w[15:1]};
                    else      exp_frame = {cur_w, cur_w};
                    check(frame == exp_frame, m_dl ? "R4" : "R3", "tx frame", frame, exp_frame);
                    check(rx_pulses == 1, "R7", "rx pulses per period", rx_pulses, 1);
                    frames_done++;
                end
            end
            if (!ws && ws_q)
                check(clocks == 32 * (int'(cfg_half_div) + 1), "R2", "ws high length",
                      clocks, 32 * (int'(cfg_half_div) + 1));
            if (!post_rst && (sd_out != sd_q || ws != ws_q) && !(sck != sck_q && sck == !m_lf))
                edge_viol++;
            if (rx_valid && active) begin
                rx_pulses++;
                check(rx_data == rx_w, "R6", "rx word from high slot", rx_data, rx_w);
            end
            post_rst = 1'b0;
            sck_q = sck; ws_q = ws; sd_q = sd_out;
        end
    end

    task automatic run_phase(input logic [DIV_W-1:0] div);
        int guard;
        @(negedge clk); #1;
        rst = 1'b1;
        cfg_half_div = div;
        cfg_launch_fall = VECS[0].lf;
        cfg_msb_delay = VECS[0].dl;
        tx_data = VECS[0].tx;
        tx_valid = VECS[0].vld;
        rxw = VECS[0].rx;
        repeat (4) @(negedge clk);
        // R10: quiet outputs during reset
        check({sck, ws, sd_out, tx_ready, rx_valid} == 5'b0, "R10", "reset outputs",
              {sck, ws, sd_out, tx_ready, rx_valid}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (i > 0) begin
                cfg_launch_fall = VECS[i].lf;
                cfg_msb_delay = VECS[i].dl;
                tx_data = VECS[i].tx;
                tx_valid = VECS[i].vld;
                rxw = VECS[i].rx;
            end
            // R8: one acceptance slot per sample period
            do @(negedge clk); while (!tx_ready);
            @(posedge clk);
            @(negedge clk);
            check(tx_ready == 1'b0, "R8", "ready single cycle", tx_ready, 0);
            @(negedge clk); #1;
        end
        tx_valid = 1'b0;
        guard = 0;
        while (frames_done < NVEC + 1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        // R9: each period kept the layout chosen before its boundary
        check(frames_done == NVEC + 1, "R9", "periods completed", frames_done, NVEC + 1);
        // R5: launch edge discipline
        check(edge_viol == 0, "R5", "changes off launch edge", edge_viol, 0);
    endtask

    initial begin
        run_phase(4'd1);
        run_phase(4'd0);
        run_phase(4'd3);
        report();
    end

endmodule